// File: doc/BRIEF.md
# Saturating Fixed-Point Multiply-Add

This block multiplies pairs of signed fixed-point operands and adds the products into one sum. All operands share one format, with `L1` integer bits and `R1` fraction bits, and the block accepts between four and eight of them. Neighbouring operands are multiplied together. When the operand count is odd, the last operand is scaled by exactly one so that its value lines up with the products. The products are then summed at full precision, which is `2·(L1+R1) + ceil(log2(N))` bits wide with `2·R1` fraction bits.

The full-precision sum is shortened to a narrower output in two steps. First a configurable number of low bits is dropped, either by truncation or, when saturation is active, by rounding. The result is then either wrapped into the output width or clamped to a symmetric or an asymmetric range. An overflow flag marks every sample that was clamped.

There are four optional pipeline registers: on the operands, on the products, on the sum, and on the saturated word together with its flag. Each one can be enabled or removed by parameter. An accumulator-mode parameter forces the sum register on. All registers that are present share one clock enable and one asynchronous clear.

Top module: `mad_sat_top`

## Requirements
- R1: Operand `i` sits at bits `[i*W +: W]` of `ops_i`, with `W = L1+R1`, in two's complement. Operands 2k and 2k+1 are multiplied together. When `N_OPS` is odd, the last operand is taken as itself times 1.0, which is its value shifted left by `R1`. All terms are summed without loss.
- R2: When `ROUND_EN` is set and the mode is symmetric or asymmetric, half the weight of the dropped bits is added before `DROP_LSB` low bits are removed. Ties therefore round toward positive infinity.
- R3: When `ROUND_EN` is clear, the low `DROP_LSB` bits are removed by arithmetic shift, which rounds toward negative infinity.
- R4: In wrap mode (`SAT_WRAP`) the output is the low `OUT_W` bits of the truncated value, `ROUND_EN` has no effect, and `ovf_o` stays 0.
- R5: In symmetric mode (`SAT_SYM`) the output is clamped to ±(2^(OUT_W−1)−1). The code −2^(OUT_W−1) never appears, and `ovf_o` is 1 exactly when clamping took place.
- R6: In asymmetric mode (`SAT_ASYM`) the output is clamped to the range −2^(OUT_W−1) to 2^(OUT_W−1)−1, and `ovf_o` is 1 exactly when clamping took place.
- R7: The latency from `ops_i` to the outputs is `REG_IN+REG_MUL+REG_ADD'+REG_SAT` clock cycles, where `REG_ADD'` is forced to 1 whenever `ACCUM_MODE` is set.
- R8: While `ce` is low, every register that is present holds its value. When at least one register is present, the outputs do not change.
- R9: Raising `clr` clears every register at once, without waiting for a clock edge. When at least one register is present, this drives `result_o` and `ovf_o` to 0.
- R10: `ovf_o` always belongs to the `result_o` value presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all pipeline registers |
| clr | input | 1 | Asynchronous clear, active high |
| ce | input | 1 | Clock enable for all pipeline registers |
| ops_i | input | N_OPS*(L1+R1) | Packed signed operands, operand i at [i*W +: W] |
| result_o | output | OUT_W | Rounded or truncated, then wrapped or saturated, sum |
| ovf_o | output | 1 | High when result_o was clamped |

## Verification
The hardest cases to reach from the ports are those where the output depends on where several products land relative to a rail. One case is a sum that rounds exactly onto the rail. Another is a sum one unit below the symmetric floor, which the symmetric mode must clamp while the asymmetric mode passes it through. Only a few operand combinations produce each of these. The bench therefore drives every combination of five 3-bit operands, one per cycle, into three instances at once: symmetric with rounding and a full pipeline, asymmetric with truncation and accumulator-forced registers, and wrap with an unused rounding request and no registers. Each output is compared against an integer model at the latency that instance should have. A stall with `ce` low and a clear in the middle of a cycle are then applied after the output has been driven onto a rail.

// File: rtl/mad_pkg.sv
package mad_pkg;

    // Output range handling after the low bits are dropped.
    typedef enum logic [1:0] {
        SAT_WRAP = 2'd0,
        SAT_SYM  = 2'd1,
        SAT_ASYM = 2'd2
    } sat_mode_e;

    // Number of multipliers for a given operand count.
    function automatic int unsigned pair_count(input int unsigned n_ops);
        return (n_ops + 1) / 2;
    endfunction

    // Clock cycles of latency for a given register selection.
    function automatic int unsigned stage_count(input bit r_in, input bit r_mul,
                                                input bit r_add, input bit r_out);
        int unsigned s;
        s = 0;
        if (r_in)  s = s + 1;
        if (r_mul) s = s + 1;
        if (r_add) s = s + 1;
        if (r_out) s = s + 1;
        return s;
    endfunction

endpackage

// File: rtl/mad_stage_reg.sv
module mad_stage_reg #(
    parameter int unsigned WIDTH  = 8,
    parameter bit          ENABLE = 1'b1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             ce,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (ENABLE) begin : g_reg
            always_ff @(posedge clk or posedge clr) begin
                if (clr)
                    q <= '0;
                else if (ce)
                    q <= d;
            end
        end else begin : g_pass
            logic unused_ctl;
            assign unused_ctl = &{1'b0, clk, clr, ce};
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/mad_pair_mul.sv
module mad_pair_mul #(
    parameter int unsigned N_OPS  = 4,
    parameter int unsigned OP_W   = 8,
    parameter int unsigned FRAC_W = 4
) (
    input  logic [N_OPS*OP_W-1:0]                           ops,
    output logic [mad_pkg::pair_count(N_OPS)*2*OP_W-1:0]    prods
);

    localparam int unsigned NP = mad_pkg::pair_count(N_OPS);
    localparam int unsigned PW = 2 * OP_W;

    generate
        for (genvar p = 0; p < NP; p++) begin : g_pair
            logic signed [OP_W-1:0] a;
            logic signed [PW-1:0]   pr;
            assign a = ops[2*p*OP_W +: OP_W];

            if (2*p + 1 < N_OPS) begin : g_mul
                logic signed [OP_W-1:0] b;
                assign b  = ops[(2*p+1)*OP_W +: OP_W];
                assign pr = a * b;
            end else begin : g_unit
                // Lone operand times 1.0: align to 2*FRAC_W fraction bits.
                assign pr = PW'(a) <<< FRAC_W;
            end

            assign prods[p*PW +: PW] = pr;
        end
    endgenerate

endmodule

// File: rtl/mad_sum.sv
module mad_sum #(
    parameter int unsigned NP = 2,
    parameter int unsigned PW = 16,
    parameter int unsigned SW = 18
) (
    input  logic [NP*PW-1:0]     prods,
    output logic signed [SW-1:0] total
);

    always_comb begin
        total = '0;
        for (int i = 0; i < NP; i++) begin
            total = total + SW'($signed(prods[i*PW +: PW]));
        end
    end

endmodule

// File: rtl/mad_saturate.sv
module mad_saturate
    import mad_pkg::*;
#(
    parameter int unsigned IN_W     = 18,
    parameter int unsigned DROP     = 8,
    parameter int unsigned OUT_W    = 8,
    parameter sat_mode_e   SAT_MODE = SAT_SYM,
    parameter bit          ROUND_EN = 1'b1
) (
    input  logic signed [IN_W-1:0] sum_i,
    output logic [OUT_W-1:0]       val_o,
    output logic                   ovf_o
);

    localparam int unsigned EW  = IN_W + 1;
    localparam int unsigned QW  = EW - DROP;
    localparam bit          DO_RND = ROUND_EN && (SAT_MODE != SAT_WRAP);
    localparam logic [EW-1:0] HALF = EW'(1) << (DROP - 1);

    localparam logic signed [QW-1:0] TOP_V  = {{(QW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [QW-1:0] FLR_A  = {{(QW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic signed [QW-1:0] FLR_V  = (SAT_MODE == SAT_SYM) ? FLR_A + QW'(1) : FLR_A;

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] adj;
    logic signed [QW-1:0] q;
    logic                 unused_lsb;

    assign ext = EW'(sum_i);

    generate
        if (DO_RND) begin : g_rnd
            assign adj = ext + $signed(HALF);
        end else begin : g_trunc
            assign adj = ext;
        end
    endgenerate

    assign q          = adj[EW-1:DROP];
    assign unused_lsb = &{1'b0, adj[DROP-1:0]};

    always_comb begin
        if (SAT_MODE == SAT_WRAP) begin
            val_o = q[OUT_W-1:0];
            ovf_o = 1'b0;
        end else if (q > TOP_V) begin
            val_o = TOP_V[OUT_W-1:0];
            ovf_o = 1'b1;
        end else if (q < FLR_V) begin
            val_o = FLR_V[OUT_W-1:0];
            ovf_o = 1'b1;
        end else begin
            val_o = q[OUT_W-1:0];
            ovf_o = 1'b0;
        end
    end

endmodule

// File: rtl/mad_sat_top.sv
module mad_sat_top
    import mad_pkg::*;
#(
    parameter int unsigned N_OPS      = 4,
    parameter int unsigned L1         = 4,
    parameter int unsigned R1         = 4,
    parameter int unsigned OUT_W      = 8,
    parameter int unsigned DROP_LSB   = 8,
    parameter sat_mode_e   SAT_MODE   = SAT_SYM,
    parameter bit          ROUND_EN   = 1'b1,
    parameter bit          REG_IN     = 1'b1,
    parameter bit          REG_MUL    = 1'b1,
    parameter bit          REG_ADD    = 1'b1,
    parameter bit          ACCUM_MODE = 1'b0,
    parameter bit          REG_SAT    = 1'b1
) (
    input  logic                        clk,
    input  logic                        clr,
    input  logic                        ce,
    input  logic [N_OPS*(L1+R1)-1:0]    ops_i,
    output logic [OUT_W-1:0]            result_o,
    output logic                        ovf_o
);

    localparam int unsigned W      = L1 + R1;
    localparam int unsigned NP     = pair_count(N_OPS);
    localparam int unsigned PW     = 2 * W;
    localparam int unsigned SW     = PW + $clog2(N_OPS);
    localparam bit          ADD_EN = REG_ADD || ACCUM_MODE;
    localparam int unsigned LAT    = stage_count(REG_IN, REG_MUL, ADD_EN, REG_SAT);

    typedef struct packed {
        logic             ovf;
        logic [OUT_W-1:0] val;
    } sat_word_t;

    logic [N_OPS*W-1:0] ops_q;
    logic [NP*PW-1:0]   prod_d, prod_q;
    logic [SW-1:0]      sum_d, sum_q;
    logic [OUT_W-1:0]   sat_val;
    logic               sat_ovf;
    sat_word_t          sat_d, sat_q;

    mad_stage_reg #(.WIDTH(N_OPS*W), .ENABLE(REG_IN)) u_in_reg (
        .clk(clk), .clr(clr), .ce(ce), .d(ops_i), .q(ops_q)
    );

    mad_pair_mul #(.N_OPS(N_OPS), .OP_W(W), .FRAC_W(R1)) u_mul (
        .ops(ops_q), .prods(prod_d)
    );

    mad_stage_reg #(.WIDTH(NP*PW), .ENABLE(REG_MUL)) u_mul_reg (
        .clk(clk), .clr(clr), .ce(ce), .d(prod_d), .q(prod_q)
    );

    mad_sum #(.NP(NP), .PW(PW), .SW(SW)) u_sum (
        .prods(prod_q), .total(sum_d)
    );

    mad_stage_reg #(.WIDTH(SW), .ENABLE(ADD_EN)) u_add_reg (
        .clk(clk), .clr(clr), .ce(ce), .d(sum_d), .q(sum_q)
    );

    mad_saturate #(
        .IN_W(SW), .DROP(DROP_LSB), .OUT_W(OUT_W),
        .SAT_MODE(SAT_MODE), .ROUND_EN(ROUND_EN)
    ) u_sat (
        .sum_i(sum_q), .val_o(sat_val), .ovf_o(sat_ovf)
    );

    // Value and flag share one register so they stay aligned.
    assign sat_d = '{ovf: sat_ovf, val: sat_val};

    mad_stage_reg #(.WIDTH($bits(sat_word_t)), .ENABLE(REG_SAT)) u_out_reg (
        .clk(clk), .clr(clr), .ce(ce), .d(sat_d), .q(sat_q)
    );

    assign result_o = sat_q.val;
    assign ovf_o    = sat_q.ovf;

    localparam logic [OUT_W-1:0] RAIL_HI   = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] RAIL_LO_A = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] RAIL_LO   = (SAT_MODE == SAT_SYM) ? RAIL_LO_A + OUT_W'(1) : RAIL_LO_A;

    generate
        if (SAT_MODE == SAT_SYM) begin : g_sym_chk
            // R5
            sym_floor_chk: assert property (@(posedge clk) disable iff (clr)
                result_o != RAIL_LO_A);
        end
        if (SAT_MODE == SAT_WRAP) begin : g_wrap_chk
            // R4
            wrap_quiet_chk: assert property (@(posedge clk) disable iff (clr)
                !ovf_o);
        end else begin : g_rail_chk
            // R10
            ovf_rail_chk: assert property (@(posedge clk) disable iff (clr)
                ovf_o |-> (result_o == RAIL_HI || result_o == RAIL_LO));
        end
        if (LAT > 0) begin : g_hold_chk
            // R8
            ce_hold_chk: assert property (@(posedge clk) disable iff (clr)
                !ce |=> ($stable(result_o) && $stable(ovf_o)));
        end
    endgenerate

endmodule

// File: tb/tb_mad_sat_top.sv
module tb_mad_sat_top;
    import mad_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NOPS = 5;
    localparam int OPW  = 3;
    localparam int OUTW = 4;
    localparam int NV   = 1 << (NOPS * OPW);

    logic clk = 1'b0;
    logic clr = 1'b1;
    logic ce  = 1'b1;
    logic [NOPS*OPW-1:0] ops = '0;

    logic [OUTW-1:0] res_s, res_a, res_w;
    logic            ovf_s, ovf_a, ovf_w;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Symmetric, rounding, all four registers: latency 4.
    mad_sat_top #(
        .N_OPS(NOPS), .L1(2), .R1(1), .OUT_W(OUTW), .DROP_LSB(2),
        .SAT_MODE(SAT_SYM), .ROUND_EN(1'b1),
        .REG_IN(1'b1), .REG_MUL(1'b1), .REG_ADD(1'b1), .ACCUM_MODE(1'b0), .REG_SAT(1'b1)
    ) dut (.clk(clk), .clr(clr), .ce(ce), .ops_i(ops), .result_o(res_s), .ovf_o(ovf_s));

    // Asymmetric, truncation, product reg + accumulator-forced sum reg: latency 2.
    mad_sat_top #(
        .N_OPS(NOPS), .L1(2), .R1(1), .OUT_W(OUTW), .DROP_LSB(2),
        .SAT_MODE(SAT_ASYM), .ROUND_EN(1'b0),
        .REG_IN(1'b0), .REG_MUL(1'b1), .REG_ADD(1'b0), .ACCUM_MODE(1'b1), .REG_SAT(1'b0)
    ) dut_asym (.clk(clk), .clr(clr), .ce(ce), .ops_i(ops), .result_o(res_a), .ovf_o(ovf_a));

    // Wrap, rounding requested but ignored, no registers: latency 0.
    mad_sat_top #(
        .N_OPS(NOPS), .L1(2), .R1(1), .OUT_W(OUTW), .DROP_LSB(2),
        .SAT_MODE(SAT_WRAP), .ROUND_EN(1'b1),
        .REG_IN(1'b0), .REG_MUL(1'b0), .REG_ADD(1'b0), .ACCUM_MODE(1'b0), .REG_SAT(1'b0)
    ) dut_wrap (.clk(clk), .clr(clr), .ce(ce), .ops_i(ops), .result_o(res_w), .ovf_o(ovf_w));

    function automatic int field(input int idx, input int i);
        int f;
        f = (idx >> (OPW * i)) & 7;
        return (f >= 4) ? f - 8 : f;
    endfunction

    // Integer model: values in units of 2^-2 (two fraction bits after products).
    function automatic void model(input int idx, input int mode, input bit rnd,
                                  output int val, output bit ov);
        int s, q, lo;
        s = field(idx, 0) * field(idx, 1) + field(idx, 2) * field(idx, 3) + field(idx, 4) * 2;
        if (rnd && mode != 0) s = s + 2;
        q  = s >>> 2;
        ov = 1'b0;
        if (mode == 0) begin
            val = q & 15;
            if (val >= 8) val = val - 16;
        end else begin
            lo = (mode == 1) ? -7 : -8;
            if (q > 7) begin
                val = 7; ov = 1'b1;
            end else if (q < lo) begin
                val = lo; ov = 1'b1;
            end else begin
                val = q;
            end
        end
    endfunction

    task automatic check(input string tag, input logic [OUTW-1:0] act, input logic aov,
                         input int ev, input bit eov);
        n_cmp++;
        if (act !== OUTW'(ev) || aov !== eov) begin
            n_bad++;
            $display("FAIL %s: got %0d ovf %b, expected %0d ovf %b",
                     tag, $signed(act), aov, ev, eov);
        end
    endtask

    task automatic check_vec(input string tag, input int which, input int idx);
        int  ev;
        bit  eov;
        case (which)
            0: begin model(idx, 1, 1'b1, ev, eov); check(tag, res_s, ovf_s, ev, eov); end
            1: begin model(idx, 2, 1'b0, ev, eov); check(tag, res_a, ovf_a, ev, eov); end
            default: begin model(idx, 0, 1'b1, ev, eov); check(tag, res_w, ovf_w, ev, eov); end
        endcase
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
            $finish;
        end
    end

    localparam int V_HI = 4 | (4 << 3) | (4 << 6) | (4 << 9) | (3 << 12);

    initial begin
        // R9: reset state while clear is held
        repeat (2) @(negedge clk);
        check("R9 reset sym", res_s, ovf_s, 0, 1'b0);
        check("R9 reset asym", res_a, ovf_a, 0, 1'b0);
        clr = 1'b0;

        // Exhaustive sweep: R1 R2 R3 R4 R5 R6 R7 R10
        for (int k = 0; k < NV + 4; k++) begin
            @(negedge clk);
            if (k >= 4) check_vec("R1/R2/R5/R7/R10 sym rounded", 0, k - 4);
            if (k >= 2) check_vec("R1/R3/R6/R7/R10 asym truncated", 1, k - 2);
            ops = (k < NV) ? (NOPS*OPW)'(k) : '0;
            #1;
            if (k < NV) check_vec("R1/R4 wrap round ignored", 2, k);
        end

        // R8: hold with clock enable low after driving onto the upper rail
        ops = (NOPS*OPW)'(V_HI);
        repeat (5) @(negedge clk);
        check_vec("R5 rail before stall", 0, V_HI);
        check_vec("R6 rail before stall", 1, V_HI);
        ce  = 1'b0;
        ops = '0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            check_vec("R8 hold sym", 0, V_HI);
            check_vec("R8 hold asym", 1, V_HI);
        end
        ce = 1'b1;
        repeat (5) @(negedge clk);
        check_vec("R8 resume sym", 0, 0);
        check_vec("R8 resume asym", 1, 0);

        // R9: clear between edges takes effect without a clock
        ops = (NOPS*OPW)'(V_HI);
        repeat (5) @(negedge clk);
        #2;
        clr = 1'b1;
        #1;
        check("R9 async clear sym", res_s, ovf_s, 0, 1'b0);
        check("R9 async clear asym", res_a, ovf_a, 0, 1'b0);
        @(negedge clk);
        clr = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule